// File: doc/BRIEF.md
# Two-Carrier Quadrature FSK Bit Demodulator

This block recovers binary data from a frequency-shift-keyed carrier without locking to the carrier phase. Each valid signed sample from the converter is multiplied by cosine and sine references at two programmable tones, the "mark" tone (data 1) and the "space" tone (data 0). The result is four mixer paths. Each path is smoothed by a first-order low-pass filter and rectified. The rectified magnitudes of each tone are summed, so the result does not depend on the carrier phase.

The two sums are integrated across one chip period. An external chip-boundary strobe marks where each period ends. At each strobe the block compares the two accumulated energies and produces one decided bit. It also presents both energies, so that software can judge the quality of the decision.

The block does not recover carrier frequency or chip timing. Both tone increments and the chip strobe are supplied from outside.

Top module: `fsk_quad_demod`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `bit_valid` is 0, `bit_out` is 0 and both energy outputs are 0. Reset also clears both phase accumulators and all four filter states.
- R2: Each tone has a PHASE_W-bit phase accumulator, starting at 0. It adds its increment (`mark_inc` or `space_inc`) once per valid sample, after the sample has been processed.
  - The reference index a is the top 4 bits of the phase.
  - The in-phase reference is round(127·cos(2πa/16)).
  - The quadrature reference is round(127·sin(2πa/16)).
- R3: On each valid sample, every path updates its state as y ← y + ((x·r − y) >>> FILT_K).
  - x is the sample and r is the path's reference.
  - `>>>` is an arithmetic (floor) shift.
- R4: The per-sample contributions are taken from the filter states after the R3 update.
  - Mark energy per sample is |y_markI| + |y_markQ|.
  - Space energy per sample is |y_spaceI| + |y_spaceQ|.
- R5: When `chip_strobe` is high at a clock edge, the energy outputs take the totals accumulated since the previous strobe. A sample that is valid at the same edge is not part of those totals; it is the first term of the new totals. A strobe with no valid sample restarts the totals at 0.
- R6: The decided bit is 1 only when the mark total is strictly greater than the space total. Equal totals give 0.
- R7: `bit_valid` is high for exactly the one cycle after each strobe edge. `bit_out` and both energy outputs keep their values until the next strobe.
- R8: Running totals saturate at 2^ACC_W − 1 and never wrap. With the default ACC_W of 24, the saturated value is 0xFFFFFF.
- R9: At an edge where `sample_valid` is low, the value of `sample_in` has no effect. Phases, filter states and totals all keep their values.
- R10: A chip with no valid samples reports both energies as 0 and a bit of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_valid | input | 1 | Qualifies `sample_in` for this edge |
| sample_in | input | SAMPLE_W | Signed converter sample |
| mark_inc | input | PHASE_W | Phase step per sample of the data-1 tone |
| space_inc | input | PHASE_W | Phase step per sample of the data-0 tone |
| chip_strobe | input | 1 | Chip boundary: latch decision, restart totals |
| bit_out | output | 1 | Decided bit of the last completed chip |
| bit_valid | output | 1 | One-cycle pulse after each chip boundary |
| mark_energy | output | ACC_W | Mark total of the last completed chip |
| space_energy | output | ACC_W | Space total of the last completed chip |

## Verification
The bench uses the default parameters: 12-bit samples, 16-bit phases, a filter shift of 2 and a 24-bit accumulator.

- The 16-bit phase puts tone steps of 1/32 to 3/8 of the sample rate within reach of short chips.
- The shift of 2 lets the filters settle inside a few samples, so matched and mismatched tones give clearly different totals within 16 to 40 samples.
- The narrow 24-bit accumulator brings saturation within reach: about 130 full-scale matched samples reach it, so the clamp is exercised in a run of a few hundred cycles.

// File: rtl/fsk_demod_pkg.sv
package fsk_demod_pkg;

    localparam int REF_W   = 8;
    localparam int LUT_A_W = 4;

    typedef logic signed [REF_W-1:0] ref_t;

    // One full sine period in 16 steps, amplitude 127.
    function automatic ref_t sine_ref(input logic [LUT_A_W-1:0] idx);
        ref_t v;
        case (idx)
            4'd0:  v = 8'sd0;
            4'd1:  v = 8'sd49;
            4'd2:  v = 8'sd90;
            4'd3:  v = 8'sd117;
            4'd4:  v = 8'sd127;
            4'd5:  v = 8'sd117;
            4'd6:  v = 8'sd90;
            4'd7:  v = 8'sd49;
            4'd8:  v = 8'sd0;
            4'd9:  v = -8'sd49;
            4'd10: v = -8'sd90;
            4'd11: v = -8'sd117;
            4'd12: v = -8'sd127;
            4'd13: v = -8'sd117;
            4'd14: v = -8'sd90;
            default: v = -8'sd49;
        endcase
        return v;
    endfunction

    // Path order inside the block: mark I, mark Q, space I, space Q.
    localparam int NUM_PATHS = 4;

endpackage

// File: rtl/fsk_nco.sv
module fsk_nco
    import fsk_demod_pkg::*;
#(
    parameter int PHASE_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adv,
    input  logic [PHASE_W-1:0] inc,
    output ref_t               cos_o,
    output ref_t               sin_o,
    output logic [PHASE_W-1:0] phase_o
);

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
    } nco_st_t;

    nco_st_t st_d, st_q;
    logic [LUT_A_W-1:0] idx;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.phase = st_q.phase + inc;
        end
        idx   = st_q.phase[PHASE_W-1 -: LUT_A_W];
        sin_o = sine_ref(idx);
        cos_o = sine_ref(idx + LUT_A_W'(4));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;

endmodule

// File: rtl/fsk_mix_lpf.sv
module fsk_mix_lpf
    import fsk_demod_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int FILT_K   = 2,
    localparam int PROD_W  = SAMPLE_W + REF_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  ref_t                       ref_i,
    output logic [PROD_W-1:0]          rect_o
);

    typedef struct packed {
        logic signed [PROD_W-1:0] y;
    } lpf_st_t;

    lpf_st_t st_d, st_q;

    logic signed [PROD_W-1:0] sx, rx, prod;
    logic signed [PROD_W:0]   diff, step;

    always_comb begin
        sx   = PROD_W'(sample_i);
        rx   = PROD_W'(ref_i);
        prod = sx * rx;
        diff = {prod[PROD_W-1], prod} - {st_q.y[PROD_W-1], st_q.y};
        step = diff >>> FILT_K;
        st_d = st_q;
        if (en) begin
            st_d.y = st_q.y + step[PROD_W-1:0];
        end
        rect_o = st_d.y[PROD_W-1] ? PROD_W'(-st_d.y) : PROD_W'(st_d.y);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fsk_quad_demod.sv
module fsk_quad_demod
    import fsk_demod_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int PHASE_W  = 16,
    parameter int FILT_K   = 2,
    parameter int ACC_W    = 24
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sample_valid,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    input  logic [PHASE_W-1:0]         mark_inc,
    input  logic [PHASE_W-1:0]         space_inc,
    input  logic                       chip_strobe,
    output logic                       bit_out,
    output logic                       bit_valid,
    output logic [ACC_W-1:0]           mark_energy,
    output logic [ACC_W-1:0]           space_energy
);

    localparam int PROD_W = SAMPLE_W + REF_W;
    localparam int SUM_W  = PROD_W + 1;

    ref_t               ref_cos [2];
    ref_t               ref_sin [2];
    logic [PHASE_W-1:0] phase   [2];
    logic [PROD_W-1:0]  rect    [NUM_PATHS];

    logic [ACC_W-1:0]   acc_mark_w;
    logic [PHASE_W-1:0] mark_phase_w, space_phase_w;

    // Carrier 0 = mark, carrier 1 = space.
    for (genvar c = 0; c < 2; c++) begin : g_carrier
        fsk_nco #(.PHASE_W(PHASE_W)) u_nco (
            .clk     (clk),
            .rst     (rst),
            .adv     (sample_valid),
            .inc     ((c == 0) ? mark_inc : space_inc),
            .cos_o   (ref_cos[c]),
            .sin_o   (ref_sin[c]),
            .phase_o (phase[c])
        );
    end

    // Path p uses carrier p/2; even paths use cosine (I), odd paths use sine (Q).
    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        fsk_mix_lpf #(.SAMPLE_W(SAMPLE_W), .FILT_K(FILT_K)) u_path (
            .clk      (clk),
            .rst      (rst),
            .en       (sample_valid),
            .sample_i (sample_in),
            .ref_i    ((p % 2 == 0) ? ref_cos[p/2] : ref_sin[p/2]),
            .rect_o   (rect[p])
        );
    end

    typedef struct packed {
        logic [ACC_W-1:0] acc_m;
        logic [ACC_W-1:0] acc_s;
        logic             bit_r;
        logic             vld;
        logic [ACC_W-1:0] e_m;
        logic [ACC_W-1:0] e_s;
    } dec_st_t;

    dec_st_t st_d, st_q;
    logic [SUM_W-1:0] sum_m, sum_s;
    logic [ACC_W-1:0] add_m, add_s, base_m, base_s;

    function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] a,
                                                 input logic [ACC_W-1:0] b);
        logic [ACC_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[ACC_W] ? '1 : s[ACC_W-1:0];
    endfunction

    always_comb begin
        sum_m  = {1'b0, rect[0]} + {1'b0, rect[1]};
        sum_s  = {1'b0, rect[2]} + {1'b0, rect[3]};
        add_m  = sample_valid ? ACC_W'(sum_m) : '0;
        add_s  = sample_valid ? ACC_W'(sum_s) : '0;
        base_m = chip_strobe ? '0 : st_q.acc_m;
        base_s = chip_strobe ? '0 : st_q.acc_s;

        st_d       = st_q;
        st_d.vld   = 1'b0;
        st_d.acc_m = sat_add(base_m, add_m);
        st_d.acc_s = sat_add(base_s, add_s);
        if (chip_strobe) begin
            st_d.vld   = 1'b1;
            st_d.e_m   = st_q.acc_m;
            st_d.e_s   = st_q.acc_s;
            st_d.bit_r = st_q.acc_m > st_q.acc_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_out       = st_q.bit_r;
    assign bit_valid     = st_q.vld;
    assign mark_energy   = st_q.e_m;
    assign space_energy  = st_q.e_s;
    assign acc_mark_w    = st_q.acc_m;
    assign mark_phase_w  = phase[0];
    assign space_phase_w = phase[1];

endmodule

// File: rtl/fsk_quad_demod_chk.sv
module fsk_quad_demod_chk #(
    parameter int PHASE_W = 16,
    parameter int ACC_W   = 24
) (
    input logic               clk,
    input logic               rst,
    input logic               sample_valid,
    input logic               chip_strobe,
    input logic               bit_out,
    input logic               bit_valid,
    input logic [ACC_W-1:0]   mark_energy,
    input logic [ACC_W-1:0]   space_energy,
    input logic [ACC_W-1:0]   acc_mark_w,
    input logic [PHASE_W-1:0] mark_phase_w,
    input logic [PHASE_W-1:0] space_phase_w
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!bit_valid && !bit_out && mark_energy == '0 && space_energy == '0));

    assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        chip_strobe |=> bit_valid);

    assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (rst)
        !chip_strobe |=> !bit_valid);

    assert_outputs_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !chip_strobe |=> ($stable(bit_out) && $stable(mark_energy) && $stable(space_energy)));

    assert_decision_rule_R6: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> (bit_out == (mark_energy > space_energy)));

    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        !chip_strobe |=> (acc_mark_w >= $past(acc_mark_w)));

    assert_empty_restart_R5: assert property (@(posedge clk) disable iff (rst)
        (chip_strobe && !sample_valid) |=> (acc_mark_w == '0));

    assert_idle_phase_R9: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |=> ($stable(mark_phase_w) && $stable(space_phase_w)));

endmodule

bind fsk_quad_demod fsk_quad_demod_chk #(
    .PHASE_W(PHASE_W),
    .ACC_W  (ACC_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (sample_valid),
    .chip_strobe  (chip_strobe),
    .bit_out      (bit_out),
    .bit_valid    (bit_valid),
    .mark_energy  (mark_energy),
    .space_energy (space_energy),
    .acc_mark_w   (acc_mark_w),
    .mark_phase_w (mark_phase_w),
    .space_phase_w(space_phase_w)
);

// File: tb/fsk_quad_demod_tb.sv
module fsk_quad_demod_tb;

    localparam int    CLK_PERIOD = 10;
    localparam int    SW  = 12;
    localparam int    PW  = 16;
    localparam int    AW  = 24;
    localparam int    K   = 2;
    localparam longint SAT = (longint'(1) << AW) - 1;
    localparam real   TWO_PI = 6.283185307179586;

    typedef struct packed {
        logic [15:0] mi;
        logic [15:0] si;
        logic [15:0] ti;
        logic [11:0] amp;
        logic [15:0] len;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{16'h1000, 16'h3000, 16'h1000, 12'd1500, 16'd32},
        '{16'h1000, 16'h3000, 16'h3000, 12'd1500, 16'd32},
        '{16'h1000, 16'h3000, 16'h1000, 12'd300,  16'd20},
        '{16'h0800, 16'h2000, 16'h2000, 12'd1800, 16'd40},
        '{16'h0800, 16'h2000, 16'h0800, 12'd900,  16'd24},
        '{16'h4000, 16'h6000, 16'h6000, 12'd2000, 16'd16}
    };

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 sample_valid;
    logic signed [SW-1:0] sample_in;
    logic [PW-1:0]        mark_inc, space_inc;
    logic                 chip_strobe;
    logic                 bit_out, bit_valid;
    logic [AW-1:0]        mark_energy, space_energy;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Model state, built from the requirements.
    longint       y [4];
    logic [15:0]  ph_m, ph_s;
    longint       acc_m, acc_s;
    longint       exp_m, exp_s;
    logic         exp_b;
    logic [15:0]  tph;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsk_quad_demod #(.SAMPLE_W(SW), .PHASE_W(PW), .FILT_K(K), .ACC_W(AW)) u_dut (
        .clk, .rst, .sample_valid, .sample_in, .mark_inc, .space_inc,
        .chip_strobe, .bit_out, .bit_valid, .mark_energy, .space_energy
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint refv(input logic [15:0] ph, input bit q);
        real a;
        a = TWO_PI * real'(ph[15:12]) / 16.0;
        return q ? longint'(int'(127.0 * $sin(a))) : longint'(int'(127.0 * $cos(a)));
    endfunction

    function automatic longint absl(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic longint sat(input longint v);
        return (v > SAT) ? SAT : v;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 4; i++) y[i] = 0;
        ph_m = '0; ph_s = '0; acc_m = 0; acc_s = 0;
        exp_m = 0; exp_s = 0; exp_b = 1'b0;
    endtask

    task automatic step(input logic v, input int x, input logic c);
        longint r [4];
        longint em, es;
        @(negedge clk);
        sample_valid = v;
        sample_in    = SW'(x);
        chip_strobe  = c;
        if (c) begin
            exp_m = acc_m; exp_s = acc_s; exp_b = (acc_m > acc_s);
            acc_m = 0; acc_s = 0;
        end
        if (v) begin
            r[0] = refv(ph_m, 0); r[1] = refv(ph_m, 1);
            r[2] = refv(ph_s, 0); r[3] = refv(ph_s, 1);
            for (int i = 0; i < 4; i++)
                y[i] = y[i] + ((longint'(x) * r[i] - y[i]) >>> K);
            em = absl(y[0]) + absl(y[1]);
            es = absl(y[2]) + absl(y[3]);
            acc_m = sat(acc_m + em);
            acc_s = sat(acc_s + es);
            ph_m = ph_m + mark_inc;
            ph_s = ph_s + space_inc;
        end
        @(posedge clk);
        #1;
        chk("R7 valid pulse", longint'(bit_valid), longint'(c));
        chk("R4 R5 mark energy", longint'(mark_energy), exp_m);
        chk("R4 R5 space energy", longint'(space_energy), exp_s);
        chk("R6 decided bit", longint'(bit_out), longint'(exp_b));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sample_valid = 1'b0; chip_strobe = 1'b0; sample_in = '0;
        model_clear();
        tph = '0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 reset valid", longint'(bit_valid), 0);
        chk("R1 reset bit", longint'(bit_out), 0);
        chk("R1 reset mark", longint'(mark_energy), 0);
        chk("R1 reset space", longint'(space_energy), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic int tone(input logic [15:0] p, input int amp);
        return int'(real'(amp) * $cos(TWO_PI * real'(p) / 65536.0));
    endfunction

    initial begin
        rst = 1'b1; sample_valid = 1'b0; chip_strobe = 1'b0;
        sample_in = '0; mark_inc = '0; space_inc = '0;
        do_reset();

        // Vector table: one chip per row, strobe with the first sample (R2 R3 R4 R5 R6).
        // Every 7th slot is an idle cycle with junk data (R9).
        for (int v = 0; v < NV; v++) begin
            mark_inc  = VECS[v].mi;
            space_inc = VECS[v].si;
            for (int i = 0; i < int'(VECS[v].len); i++) begin
                step(1'b1, tone(tph, int'(VECS[v].amp)), (i == 0));
                tph = tph + VECS[v].ti;
                if (i % 7 == 3) step(1'b0, int'($urandom_range(0, 4095)) - 2048, 1'b0);
            end
        end
        step(1'b0, 0, 1'b1);

        // R10: chip with no samples.
        step(1'b0, 1234, 1'b1);
        chk("R10 empty mark", longint'(mark_energy), 0);
        chk("R10 empty bit", longint'(bit_out), 0);

        // R6 tie: equal tones from reset give equal totals, bit 0.
        do_reset();
        mark_inc = 16'h1000; space_inc = 16'h1000;
        for (int i = 0; i < 12; i++) begin
            step(1'b1, tone(tph, 1700), 1'b0);
            tph = tph + 16'h1000;
        end
        step(1'b0, 0, 1'b1);
        chk("R6 tie equal totals", longint'(mark_energy), longint'(space_energy));
        chk("R6 tie bit zero", longint'(bit_out), 0);
        chk("R6 tie nonzero", longint'(mark_energy != 0), 1);

        // R8: full-scale matched tone saturates the mark total.
        do_reset();
        mark_inc = 16'h1000; space_inc = 16'h5000;
        for (int i = 0; i < 300; i++) begin
            step(1'b1, tone(tph, 2047), 1'b0);
            tph = tph + 16'h1000;
        end
        step(1'b0, 0, 1'b1);
        chk("R8 saturated mark", longint'(mark_energy), SAT);
        chk("R8 mark wins", longint'(bit_out), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule